// File: doc/BRIEF.md
# Oversampling Serial Receiver with Two-Entry Character Buffer

This block receives asynchronous serial characters on a single line. A baud-tick pulse comes from outside at the oversampling rate. Each tick, the receiver samples a synchronised copy of the line. A falling edge that follows an idle-high sample starts a frame. The receiver then counts samples to find the middle of each bit, and settles each bit by a two-of-three vote over three samples near that middle. The ratio of samples per bit can be switched at run time between 16 and 8. The ratio and the parity mode are captured when a frame starts, so a change during a frame affects only the next one.

Each completed character goes into a small buffer. It is stored together with its own parity-error and framing-error status. The head of the buffer leaves on a valid/ready stream. `rd_valid` high means a character waits on `rd_data`, `rd_par_err` and `rd_frm_err`. These outputs hold steady until the consumer raises `rd_ready` in a cycle where `rd_valid` is high. That cycle pops the entry.

There is no back-pressure toward the serial line. A character that completes while both entries are occupied is discarded, and the sticky `overrun` flag is raised. Dropping `rx_en` abandons any frame in progress at once and empties the buffer. Software may also empty the buffer by popping until `rd_valid` falls.

Top module: `urx_receiver`

## Requirements
- R1: With `dbl_speed`=0, a frame made of one low start bit, 8 data bits sent LSB first and one high stop bit, each bit 16 ticks long, yields that byte on `rd_data` with `rd_valid`=1 and both error outputs 0.
- R2: With `dbl_speed`=1 when the start edge arrives, the same frame with 8 ticks per bit is received correctly.
- R3: Counting the tick that first sees the falling edge as sample 1 of the start bit, each bit's value is the majority of its samples 8, 9 and 10 in 16x mode, or of samples 4, 5 and 6 in 8x mode. All other samples of the bit have no effect.
- R4: If the start bit's vote gives 1, the receiver treats it as a glitch. It stores nothing and waits for the next falling edge.
- R5: A low line with no high sample seen since reset, enable, or a low stop bit does not start a frame. High samples keep the receiver idle.
- R6: `par_mode` encoding: bit 1 set enables a parity bit between the last data bit and the stop bit. Bit 0 selects odd (1) or even (0) parity. An entry's parity-error status is 1 when the count of ones in the data plus the parity bit does not match the selected parity.
- R7: Parity-error status is 0 for characters received with parity disabled. A stored status does not change when `par_mode` changes before the entry is read.
- R8: A stop bit that votes 0 sets the framing-error status of that entry. The data bits are still stored.
- R9: The buffer holds 2 entries in arrival order. While `rd_valid`=1 and `rd_ready`=0, the head's data and flags do not change.
- R10: A character completing while 2 entries are stored is discarded and sets `overrun`. `overrun` stays set until the next pop clears it.
- R11: `rx_en`=0 abandons the current frame in the next cycle, empties the buffer and clears `overrun`.
- R12: Popping repeatedly until `rd_valid` falls empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at the oversampling rate |
| rx | input | 1 | Serial input line, idle high |
| rx_en | input | 1 | Receiver enable; low aborts and flushes |
| dbl_speed | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| par_mode | input | 2 | Bit 1 enables parity, bit 0 selects odd |
| rd_valid | output | 1 | Buffer head holds a character |
| rd_ready | input | 1 | Consumer accepts the head this cycle |
| rd_data | output | 8 | Head character |
| rd_par_err | output | 1 | Parity-error status of the head |
| rd_frm_err | output | 1 | Framing-error status of the head |
| overrun | output | 1 | Sticky: a character was dropped because the buffer was full |

## Verification
A sample counter that is off by one would move the vote window. The noisy-bit patterns would then show it at once: the byte read back after that same frame would be wrong. A lost or stuck parity accumulator shows in the parity-error output of the next entry. A buffer pointer or count that has gone wrong shows within two pops: an entry comes back out of order, appears twice, or `rd_valid` stays high past the second pop. The 8x sweep covers every byte value with even parity. It therefore exposes any data path or parity bit that drops or sticks, on the first frame that needs it.

// File: rtl/urx_pkg.sv
package urx_pkg;
  parameter int URX_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } urx_state_e;

  typedef struct packed {
    logic [URX_DW-1:0] data;
    logic              perr;
    logic              ferr;
  } urx_char_t;
endpackage

// File: rtl/urx_sync.sv
module urx_sync #(
  parameter int   STAGES = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= RST_VAL;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i > 0) ? i-1 : 0];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/urx_deframer.sv
module urx_deframer
  import urx_pkg::*;
#(
  parameter int OS_NORM = 16,
  parameter int OS_FAST = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      tick,
  input  logic      rx_s,
  input  logic      dbl,
  input  logic [1:0] pmode,
  output logic      char_vld,
  output urx_char_t char_out
);
  localparam int CW = $clog2(OS_NORM + 1);
  localparam int IW = $clog2(URX_DW + 1);
  localparam logic [CW-1:0] MID_N  = CW'(OS_NORM / 2);
  localparam logic [CW-1:0] MID_F  = CW'(OS_FAST / 2);
  localparam logic [CW-1:0] LAST_N = CW'(OS_NORM);
  localparam logic [CW-1:0] LAST_F = CW'(OS_FAST);
  localparam logic [IW-1:0] LAST_BIT = IW'(URX_DW - 1);

  urx_state_e        state;
  logic [CW-1:0]     cnt;
  logic [1:0]        ones;
  logic              armed;
  logic              fast_l;
  logic [1:0]        pmode_l;
  logic [IW-1:0]     bit_idx;
  logic [URX_DW-1:0] shreg;
  logic              par_acc;

  logic [CW-1:0] mid, last, cnt_n;
  logic          in_win, decide, at_last, vote;
  logic [1:0]    ones_n;

  always_comb begin
    mid     = fast_l ? MID_F : MID_N;
    last    = fast_l ? LAST_F : LAST_N;
    cnt_n   = cnt + 1'b1;
    in_win  = (cnt_n >= mid) && (cnt_n <= mid + 2'd2);
    ones_n  = ones + ((in_win && rx_s) ? 2'd1 : 2'd0);
    decide  = (cnt_n == mid + 2'd2);
    at_last = (cnt_n == last);
    vote    = ones_n[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ones     <= '0;
      armed    <= 1'b0;
      fast_l   <= 1'b0;
      pmode_l  <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      par_acc  <= 1'b0;
      char_vld <= 1'b0;
      char_out <= '0;
    end else if (!en) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ones     <= '0;
      armed    <= 1'b0;
      char_vld <= 1'b0;
    end else begin
      char_vld <= 1'b0;
      if (tick) begin
        if (state == ST_IDLE) begin
          if (rx_s) begin
            armed <= 1'b1;
          end else if (armed) begin
            state   <= ST_START;
            cnt     <= CW'(1);
            ones    <= '0;
            armed   <= 1'b0;
            fast_l  <= dbl;
            pmode_l <= pmode;
            bit_idx <= '0;
            par_acc <= 1'b0;
          end
        end else begin
          cnt  <= at_last ? '0 : cnt_n;
          ones <= at_last ? 2'd0 : ones_n;
          case (state)
            ST_START: begin
              if (decide && vote) begin
                state <= ST_IDLE;
                cnt   <= '0;
                ones  <= '0;
              end else if (at_last) begin
                state <= ST_DATA;
              end
            end
            ST_DATA: begin
              if (decide) begin
                shreg   <= {vote, shreg[URX_DW-1:1]};
                par_acc <= par_acc ^ vote;
              end
              if (at_last) begin
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx == LAST_BIT) state <= pmode_l[1] ? ST_PAR : ST_STOP;
              end
            end
            ST_PAR: begin
              if (decide) par_acc <= par_acc ^ vote;
              if (at_last) state <= ST_STOP;
            end
            ST_STOP: begin
              if (decide) begin
                char_vld      <= 1'b1;
                char_out.data <= shreg;
                char_out.ferr <= ~vote;
                char_out.perr <= pmode_l[1] & (par_acc ^ pmode_l[0]);
                state         <= ST_IDLE;
                cnt           <= '0;
                ones          <= '0;
                armed         <= vote;
              end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  p_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_IDLE) && !char_vld);

  p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) && tick && rx_s |=> (state == ST_IDLE));

  p_single_push_r9: assert property (@(posedge clk) disable iff (!rst_n)
    char_vld |=> !char_vld);
endmodule

// File: rtl/urx_fifo.sv
module urx_fifo
  import urx_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      flush,
  input  logic      push,
  input  urx_char_t push_data,
  input  logic      pop,
  output logic      out_valid,
  output urx_char_t out_data,
  output logic      ovr
);
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);
  localparam logic [CNTW-1:0] FULL_CNT = CNTW'(DEPTH);
  localparam logic [PW-1:0]   LAST_PTR = PW'(DEPTH - 1);

  urx_char_t       mem [DEPTH];
  logic [PW-1:0]   wptr, rptr;
  logic [CNTW-1:0] count;
  logic            full, push_ok, pop_ok;

  assign full      = (count == FULL_CNT);
  assign out_valid = (count != '0);
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && out_valid && !flush;
  assign out_data  = mem[rptr];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem[i] <= '0;
        else if (push_ok && wptr == PW'(i)) mem[i] <= push_data;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      ovr   <= 1'b0;
    end else begin
      if (push_ok) wptr <= (wptr == LAST_PTR) ? '0 : wptr + 1'b1;
      if (pop_ok)  rptr <= (rptr == LAST_PTR) ? '0 : rptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (push && full) ovr <= 1'b1;
      else if (pop_ok)  ovr <= 1'b0;
    end
  end

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);

  p_head_hold_r9: assert property (@(posedge clk) disable iff (!rst_n || flush)
    out_valid && !pop |=> out_valid && $stable(out_data));

  p_overrun_set_r10: assert property (@(posedge clk) disable iff (!rst_n || flush)
    push && full |=> ovr);

  p_flush_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid && !ovr);
endmodule

// File: rtl/urx_receiver.sv
module urx_receiver
  import urx_pkg::*;
#(
  parameter int OS_NORM     = 16,
  parameter int OS_FAST     = 8,
  parameter int DEPTH       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx,
  input  logic              rx_en,
  input  logic              dbl_speed,
  input  logic [1:0]        par_mode,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [URX_DW-1:0] rd_data,
  output logic              rd_par_err,
  output logic              rd_frm_err,
  output logic              overrun
);
  logic      rx_s;
  logic      char_vld;
  urx_char_t char_w;
  urx_char_t head;

  urx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rx),
    .q     (rx_s)
  );

  urx_deframer #(.OS_NORM(OS_NORM), .OS_FAST(OS_FAST)) u_deframer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (rx_en),
    .tick     (baud_tick),
    .rx_s     (rx_s),
    .dbl      (dbl_speed),
    .pmode    (par_mode),
    .char_vld (char_vld),
    .char_out (char_w)
  );

  urx_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!rx_en),
    .push      (char_vld),
    .push_data (char_w),
    .pop       (rd_ready),
    .out_valid (rd_valid),
    .out_data  (head),
    .ovr       (overrun)
  );

  assign rd_data    = head.data;
  assign rd_par_err = head.perr;
  assign rd_frm_err = head.ferr;
endmodule

// File: tb/test_urx_receiver.sv
module test_urx_receiver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b0;
  logic       rx_en = 1'b1;
  logic       dbl_speed = 1'b0;
  logic [1:0] par_mode = 2'b00;
  logic       rd_ready = 1'b0;
  logic       rd_valid, rd_par_err, rd_frm_err, overrun;
  logic [7:0] rd_data;
  logic [1:0] phase = 2'd0;
  logic       baud_tick;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(negedge clk) phase <= phase + 2'd1;
  assign baud_tick = (phase == 2'd0);

  urx_receiver i_urx_receiver (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx(rx), .rx_en(rx_en),
    .dbl_speed(dbl_speed), .par_mode(par_mode), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .rd_data(rd_data), .rd_par_err(rd_par_err),
    .rd_frm_err(rd_frm_err), .overrun(overrun)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one sample period: rx changes two clocks before the next tick
  task automatic smp(input logic v);
    @(negedge clk);
    while (phase != 2'd1) @(negedge clk);
    rx = v;
  endtask

  task automatic smp_n(input logic v, input int n);
    for (int i = 0; i < n; i++) smp(v);
  endtask

  task automatic send_bit(input logic v, input int os, input logic [15:0] nmask);
    for (int s = 0; s < os; s++) smp(v ^ nmask[s]);
  endtask

  // nbit: data bit receiving the noise mask, 8 = every data bit
  task automatic send_frame(input logic [7:0] d, input logic fast, input logic [1:0] pm,
                            input logic bad_par, input logic stop_v,
                            input logic [15:0] nmask, input int nbit);
    int os;
    os = fast ? 8 : 16;
    dbl_speed = fast;
    par_mode  = pm;
    smp_n(1'b1, 2);
    send_bit(1'b0, os, 16'h0);
    for (int b = 0; b < 8; b++)
      send_bit(d[b], os, (nbit == 8 || nbit == b) ? nmask : 16'h0);
    if (pm[1]) send_bit((^d) ^ pm[0] ^ bad_par, os, 16'h0);
    send_bit(stop_v, os, 16'h0);
    smp_n(1'b1, 2);
  endtask

  task automatic expect_pop(input string req, input logic [7:0] d, input logic pe, input logic fe);
    @(negedge clk);
    chk(req, {31'd0, rd_valid}, 32'd1);
    chk(req, {24'd0, rd_data}, {24'd0, d});
    chk(req, {30'd0, rd_par_err, rd_frm_err}, {30'd0, pe, fe});
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset rd_valid", {31'd0, rd_valid}, 32'd0);
    chk("reset overrun", {31'd0, overrun}, 32'd0);

    // R5: line low since reset never starts a frame
    smp_n(1'b0, 40);
    chk("R5 low line no frame", {31'd0, rd_valid}, 32'd0);
    smp_n(1'b1, 4);

    // R1: 16x basic frames
    send_frame(8'hA5, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    expect_pop("R1 16x A5", 8'hA5, 1'b0, 1'b0);
    send_frame(8'h01, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    expect_pop("R1 16x 01", 8'h01, 1'b0, 1'b0);

    // R3: noise outside the vote window on every data bit
    send_frame(8'h3C, 1'b0, 2'b00, 1'b0, 1'b1, 16'hFC7F, 8);
    expect_pop("R3 16x outside window", 8'h3C, 1'b0, 1'b0);
    send_frame(8'hC3, 1'b1, 2'b00, 1'b0, 1'b1, 16'h00C7, 8);
    expect_pop("R3 8x outside window", 8'hC3, 1'b0, 1'b0);
    send_frame(8'h00, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0100, 3);
    expect_pop("R3 one of three flipped", 8'h00, 1'b0, 1'b0);
    send_frame(8'h00, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0180, 3);
    expect_pop("R3 two of three flipped", 8'h08, 1'b0, 1'b0);

    // R4: start glitch of 5 samples
    dbl_speed = 1'b0;
    smp_n(1'b0, 5);
    smp_n(1'b1, 30);
    chk("R4 glitch stores nothing", {31'd0, rd_valid}, 32'd0);
    send_frame(8'h5A, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    expect_pop("R4 frame after glitch", 8'h5A, 1'b0, 1'b0);
    @(negedge clk);
    chk("R4 exactly one entry", {31'd0, rd_valid}, 32'd0);

    // R6: parity 16x, even and odd, good and bad
    for (int i = 0; i < 24; i++) begin
      logic [7:0] d;
      logic [1:0] pm;
      logic bp;
      d  = 8'(i * 37 + 11);
      pm = (i % 2 == 0) ? 2'b10 : 2'b11;
      bp = ((i / 2) % 2) == 1;
      send_frame(d, 1'b0, pm, bp, 1'b1, 16'h0, 0);
      expect_pop("R6 parity 16x", d, bp, 1'b0);
    end

    // R7: stored parity status survives a mode change; none mode gives 0
    send_frame(8'h77, 1'b0, 2'b10, 1'b1, 1'b1, 16'h0, 0);
    par_mode = 2'b00;
    @(negedge clk);
    expect_pop("R7 status kept after mode change", 8'h77, 1'b1, 1'b0);
    send_frame(8'h77, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    expect_pop("R7 no parity gives 0", 8'h77, 1'b0, 1'b0);

    // R8: low stop bit
    send_frame(8'h96, 1'b0, 2'b00, 1'b0, 1'b0, 16'h0, 0);
    expect_pop("R8 frame error", 8'h96, 1'b0, 1'b1);
    send_frame(8'h69, 1'b1, 2'b11, 1'b0, 1'b0, 16'h0, 0);
    expect_pop("R8 frame error 8x", 8'h69, 1'b0, 1'b1);

    // R9, R10: fill, overrun, ordering, clear on read
    send_frame(8'h11, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    send_frame(8'h22, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    chk("R9 head held while not ready", {24'd0, rd_data}, 32'h11);
    chk("R10 no overrun at two", {31'd0, overrun}, 32'd0);
    send_frame(8'h33, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    chk("R10 overrun set", {31'd0, overrun}, 32'd1);
    expect_pop("R9 first in order", 8'h11, 1'b0, 1'b0);
    chk("R10 overrun cleared by pop", {31'd0, overrun}, 32'd0);
    expect_pop("R10 third dropped", 8'h22, 1'b0, 1'b0);
    @(negedge clk);
    chk("R9 empty after two", {31'd0, rd_valid}, 32'd0);

    // R12: flush by popping until empty
    send_frame(8'hAA, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    send_frame(8'hBB, 1'b1, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    begin
      int pops;
      pops = 0;
      @(negedge clk);
      while (rd_valid && pops < 5) begin
        rd_ready = 1'b1;
        @(negedge clk);
        rd_ready = 1'b0;
        pops++;
      end
      chk("R12 pops to empty", pops, 32'd2);
      chk("R12 empty", {31'd0, rd_valid}, 32'd0);
    end

    // R11: disable flushes stored data and aborts a frame
    send_frame(8'hCC, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    send_frame(8'hDD, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    send_frame(8'hEE, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    chk("R11 setup overrun", {31'd0, overrun}, 32'd1);
    smp_n(1'b1, 2);
    send_bit(1'b0, 16, 16'h0);
    send_bit(1'b1, 16, 16'h0);
    send_bit(1'b0, 16, 16'h0);
    @(negedge clk);
    rx_en = 1'b0;
    @(negedge clk);
    chk("R11 flushed", {31'd0, rd_valid}, 32'd0);
    chk("R11 overrun cleared", {31'd0, overrun}, 32'd0);
    rx_en = 1'b1;
    smp_n(1'b1, 200);
    chk("R11 aborted frame gives nothing", {31'd0, rd_valid}, 32'd0);
    send_frame(8'h42, 1'b0, 2'b00, 1'b0, 1'b1, 16'h0, 0);
    expect_pop("R11 clean frame after abort", 8'h42, 1'b0, 1'b0);

    // R2: sweep of all byte values at 8x with even parity
    for (int v = 0; v < 256; v++) begin
      send_frame(8'(v), 1'b1, 2'b10, 1'b0, 1'b1, 16'h0, 0);
      expect_pop("R2 8x sweep", 8'(v), 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule